// File: doc/BRIEF.md
# Adjustable Conversion-Rate Timing Generator

This block turns one master clock into the pacing signals of a two-section data converter: a square-wave filter clock and a one-cycle conversion strobe for the transmit section, and the same pair for the receive section. Each section owns a two-stage divider. The first stage counts master clocks and flips the filter clock each time it expires. The second stage counts filter-clock periods and fires the conversion strobe once per conversion period.

Software can nudge the timing of a single conversion. It posts a two-bit adjust request together with a signed trim value. At the next conversion boundary the first-stage divider is reloaded once with its base value plus or minus the trim. That moves the following strobe later or earlier by a whole number of master clocks, and the dividers then go back to plain reloads. A synchronous-mode input makes the receive outputs follow the transmit dividers, so that both sections run from one timebase.

Top module: `timing_rate_gen`

## Requirements
- R1: While reset is asserted, all four outputs (both filter clocks and both strobes) are low.
- R2: A section's filter clock is a square wave whose high and low phases each last A master clocks, where A is that section's first-stage base value.
- R3: With no adjust pending, a section's conversion strobe is high for exactly one master clock, and it repeats every 2*A*B master clocks, where B is the second-stage base value.
- R4: An adjust request with code 2'b01 makes the period that starts at the next strobe last 2*A*B + D master clocks. Code 2'b10 makes that period last 2*A*B - D. D is the trim, read as two's complement.
- R5: Adjust codes 2'b00 and 2'b11 leave the period unchanged.
- R6: An adjustment affects only one period. The period after the adjusted one is again 2*A*B.
- R7: If the adjusted first-stage load would be below 1, it is taken as 1. The adjusted period is then 2*A*B - A + 1.
- R8: With sync_mode low, the receive section runs from its own base values. Its strobe period is 2*A_rx*B_rx.
- R9: With sync_mode high, the receive filter clock and strobe equal the transmit ones in every cycle. Receive base values and receive adjust requests have no effect on the receive outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1: receive outputs follow the transmit dividers |
| tx_a_base | input | A_W | Transmit first-stage base divide value |
| tx_a_adj | input | ADJ_W | Transmit signed trim (two's complement) |
| tx_b_base | input | B_W | Transmit second-stage base divide value |
| tx_adj_valid | input | 1 | One-cycle pulse that posts a transmit adjust request |
| tx_adj_sel | input | 2 | Transmit adjust code: 01 later, 10 earlier, 00/11 none |
| rx_a_base | input | A_W | Receive first-stage base divide value |
| rx_a_adj | input | ADJ_W | Receive signed trim |
| rx_b_base | input | B_W | Receive second-stage base divide value |
| rx_adj_valid | input | 1 | One-cycle pulse that posts a receive adjust request |
| rx_adj_sel | input | 2 | Receive adjust code |
| tx_fclk | output | 1 | Transmit filter clock |
| tx_conv | output | 1 | Transmit conversion strobe |
| rx_fclk | output | 1 | Receive filter clock |
| rx_conv | output | 1 | Receive conversion strobe |

## Verification
The bench builds the block with A_W=4, ADJ_W=3 and B_W=3. With these widths the bench can sweep every nonzero pair of first-stage and second-stage base values on both sections, and every trim value from -4 to 3 under all four adjust codes. Short periods also bring the clamp to 1 within reach with small trims.

// File: rtl/tgen_pkg.sv
package tgen_pkg;
   typedef enum logic [1:0] {
      TRIM_HOLD   = 2'b00,
      TRIM_LATER  = 2'b01,
      TRIM_SOONER = 2'b10,
      TRIM_HOLD2  = 2'b11
   } trim_code_e;
endpackage

// File: rtl/tgen_load_calc.sv
module tgen_load_calc
   import tgen_pkg::*;
#(
   parameter int A_W   = 6,
   parameter int ADJ_W = 5
) (
   input  logic [A_W-1:0]   base,
   input  logic [ADJ_W-1:0] trim,
   input  trim_code_e       code,
   input  logic             apply,
   output logic [A_W:0]     load
);
   localparam int SW = A_W + 2;
   localparam logic signed [SW-1:0] ONE = SW'(1);

   logic signed [SW-1:0] base_s;
   logic signed [SW-1:0] trim_s;
   logic signed [SW-1:0] sum;

   always_comb begin
      base_s = $signed({2'b00, base});
      trim_s = $signed({{(SW-ADJ_W){trim[ADJ_W-1]}}, trim});
      sum    = base_s;
      if (apply) begin
         case (code)
            TRIM_LATER:  sum = base_s + trim_s;
            TRIM_SOONER: sum = base_s - trim_s;
            default:     sum = base_s;
         endcase
      end
      if (sum < ONE) load = (A_W+1)'(1);
      else           load = sum[A_W:0];
   end
endmodule

// File: rtl/tgen_chan.sv
module tgen_chan
   import tgen_pkg::*;
#(
   parameter int A_W   = 6,
   parameter int ADJ_W = 5,
   parameter int B_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [A_W-1:0]   a_base,
   input  logic [ADJ_W-1:0] a_trim,
   input  logic [B_W-1:0]   b_base,
   input  logic             req_valid,
   input  logic [1:0]       req_code,
   output logic             fclk,
   output logic             conv
);
   localparam int CA = A_W + 1;
   localparam int CB = B_W + 1;

   logic [CA-1:0] a_cnt;
   logic [CB-1:0] b_cnt;
   logic [CA-1:0] a_load;
   logic [CB-1:0] b_load;
   logic          pend;
   trim_code_e    pend_code;
   logic          tick;
   logic          boundary;

   assign tick     = (a_cnt <= CA'(1));
   assign boundary = tick && (b_cnt <= CB'(1));
   assign b_load   = (b_base == '0) ? CB'(2) : {b_base, 1'b0};

   tgen_load_calc #(.A_W(A_W), .ADJ_W(ADJ_W)) u_calc (
      .base  (a_base),
      .trim  (a_trim),
      .code  (pend_code),
      .apply (boundary && pend),
      .load  (a_load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cnt     <= CA'(1);
         b_cnt     <= CB'(1);
         fclk      <= 1'b0;
         conv      <= 1'b0;
         pend      <= 1'b0;
         pend_code <= TRIM_HOLD;
      end else begin
         conv <= boundary;
         if (tick) begin
            a_cnt <= a_load;
            fclk  <= ~fclk;
            b_cnt <= boundary ? b_load : b_cnt - CB'(1);
         end else begin
            a_cnt <= a_cnt - CA'(1);
         end
         if (req_valid) begin
            pend      <= 1'b1;
            pend_code <= trim_code_e'(req_code);
         end else if (boundary) begin
            pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/timing_rate_gen.sv
module timing_rate_gen #(
   parameter int A_W   = 6,
   parameter int ADJ_W = 5,
   parameter int B_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_mode,
   input  logic [A_W-1:0]   tx_a_base,
   input  logic [ADJ_W-1:0] tx_a_adj,
   input  logic [B_W-1:0]   tx_b_base,
   input  logic             tx_adj_valid,
   input  logic [1:0]       tx_adj_sel,
   input  logic [A_W-1:0]   rx_a_base,
   input  logic [ADJ_W-1:0] rx_a_adj,
   input  logic [B_W-1:0]   rx_b_base,
   input  logic             rx_adj_valid,
   input  logic [1:0]       rx_adj_sel,
   output logic             tx_fclk,
   output logic             tx_conv,
   output logic             rx_fclk,
   output logic             rx_conv
);
   localparam int NCH = 2;

   if (A_W < 2 || B_W < 1) begin : g_bad_width
      $error("timing_rate_gen: divider widths too small");
   end
   if (ADJ_W < 2 || ADJ_W > A_W) begin : g_bad_trim
      $error("timing_rate_gen: trim width must lie in 2..A_W");
   end

   logic [A_W-1:0]   a_base_v [NCH];
   logic [ADJ_W-1:0] a_trim_v [NCH];
   logic [B_W-1:0]   b_base_v [NCH];
   logic             valid_v  [NCH];
   logic [1:0]       code_v   [NCH];
   logic             fclk_v   [NCH];
   logic             conv_v   [NCH];

   assign a_base_v[0] = tx_a_base;
   assign a_trim_v[0] = tx_a_adj;
   assign b_base_v[0] = tx_b_base;
   assign valid_v[0]  = tx_adj_valid;
   assign code_v[0]   = tx_adj_sel;
   assign a_base_v[1] = rx_a_base;
   assign a_trim_v[1] = rx_a_adj;
   assign b_base_v[1] = rx_b_base;
   assign valid_v[1]  = rx_adj_valid;
   assign code_v[1]   = rx_adj_sel;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      tgen_chan #(.A_W(A_W), .ADJ_W(ADJ_W), .B_W(B_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .a_base    (a_base_v[c]),
         .a_trim    (a_trim_v[c]),
         .b_base    (b_base_v[c]),
         .req_valid (valid_v[c]),
         .req_code  (code_v[c]),
         .fclk      (fclk_v[c]),
         .conv      (conv_v[c])
      );
   end

   assign tx_fclk = fclk_v[0];
   assign tx_conv = conv_v[0];
   assign rx_fclk = sync_mode ? fclk_v[0] : fclk_v[1];
   assign rx_conv = sync_mode ? conv_v[0] : conv_v[1];
endmodule

// File: rtl/tgen_checker.sv
module tgen_checker (
   input logic clk,
   input logic rst_n,
   input logic sync_mode,
   input logic tx_fclk,
   input logic tx_conv,
   input logic rx_fclk,
   input logic rx_conv
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> !tx_fclk && !tx_conv && !rx_fclk && !rx_conv);

   assert_tx_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_conv |=> !tx_conv);

   assert_tx_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_conv |-> $rose(tx_fclk));

   assert_rx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_conv && !sync_mode) |=> (!rx_conv || sync_mode));

   assert_rx_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_conv && !sync_mode && !$past(sync_mode)) |-> $rose(rx_fclk));
endmodule

bind timing_rate_gen tgen_checker u_tgen_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_mode (sync_mode),
   .tx_fclk   (tx_fclk),
   .tx_conv   (tx_conv),
   .rx_fclk   (rx_fclk),
   .rx_conv   (rx_conv)
);

// File: tb/tb_timing_rate_gen.sv
`timescale 1ns/1ps
module tb_timing_rate_gen;
   localparam int A_W = 4;
   localparam int ADJ_W = 3;
   localparam int B_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_mode = 1'b0;
   logic [A_W-1:0] tx_a_base = 4'd1, rx_a_base = 4'd1;
   logic [ADJ_W-1:0] tx_a_adj = '0, rx_a_adj = '0;
   logic [B_W-1:0] tx_b_base = 3'd1, rx_b_base = 3'd1;
   logic tx_adj_valid = 1'b0, rx_adj_valid = 1'b0;
   logic [1:0] tx_adj_sel = 2'b00, rx_adj_sel = 2'b00;
   logic tx_fclk, tx_conv, rx_fclk, rx_conv;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   timing_rate_gen #(.A_W(A_W), .ADJ_W(ADJ_W), .B_W(B_W)) dut (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
      .tx_a_base(tx_a_base), .tx_a_adj(tx_a_adj), .tx_b_base(tx_b_base),
      .tx_adj_valid(tx_adj_valid), .tx_adj_sel(tx_adj_sel),
      .rx_a_base(rx_a_base), .rx_a_adj(rx_a_adj), .rx_b_base(rx_b_base),
      .rx_adj_valid(rx_adj_valid), .rx_adj_sel(rx_adj_sel),
      .tx_fclk(tx_fclk), .tx_conv(tx_conv), .rx_fclk(rx_fclk), .rx_conv(rx_conv)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic conv_of(input bit rx);
      return rx ? rx_conv : tx_conv;
   endfunction

   function automatic logic fclk_of(input bit rx);
      return rx ? rx_fclk : tx_fclk;
   endfunction

   // Ends at a negedge where the strobe is high; returns cycles since the previous strobe.
   task automatic meas(input bit rx, output int n);
      while (!conv_of(rx)) @(negedge clk);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!conv_of(rx));
   endtask

   task automatic fhigh(input bit rx, output int n);
      while (fclk_of(rx)) @(negedge clk);
      while (!fclk_of(rx)) @(negedge clk);
      n = 0;
      while (fclk_of(rx)) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic tx_post(input logic [1:0] code);
      tx_adj_sel = code;
      tx_adj_valid = 1'b1;
      fork
         begin
            @(negedge clk);
            tx_adj_valid = 1'b0;
         end
      join_none
   endtask

   initial begin
      #700000;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n, n1, n2, n3, mism, base, exp;
      repeat (3) @(negedge clk);
      check("R1 tx_fclk", tx_fclk, 0);
      check("R1 tx_conv", tx_conv, 0);
      check("R1 rx_fclk", rx_fclk, 0);
      check("R1 rx_conv", rx_conv, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2, R3, R8: sweep of base values on both sections
      for (int a = 1; a < 16; a++) begin
         for (int b = 1; b < 8; b++) begin
            tx_a_base = 4'(a);
            tx_b_base = 3'(b);
            rx_a_base = 4'(16 - a);
            rx_b_base = 3'(8 - b);
            meas(1'b0, n);
            meas(1'b0, n);
            check("R3 tx period", n, 2 * a * b);
            fhigh(1'b0, n);
            check("R2 tx fclk high", n, a);
            meas(1'b1, n);
            meas(1'b1, n);
            check("R8 rx period", n, 2 * (16 - a) * (8 - b));
         end
      end

      // R4, R5, R6: trim sweep with A=5, B=2
      tx_a_base = 4'd5;
      tx_b_base = 3'd2;
      base = 20;
      for (int d = -4; d < 4; d++) begin
         for (int s = 0; s < 4; s++) begin
            tx_a_adj = 3'(d);
            meas(1'b0, n);
            meas(1'b0, n);
            tx_post(2'(s));
            meas(1'b0, n1);
            meas(1'b0, n2);
            meas(1'b0, n3);
            check("R6 request period", n1, base);
            if (s == 1) begin
               exp = base + d;
               check("R4 later", n2, exp);
            end else if (s == 2) begin
               exp = base - d;
               check("R4 sooner", n2, exp);
            end else begin
               check("R5 no trim", n2, base);
            end
            check("R6 back to plain", n3, base);
         end
      end

      // R7: clamp with A=2, B=2
      tx_a_base = 4'd2;
      tx_b_base = 3'd2;
      tx_a_adj = 3'(3);
      meas(1'b0, n);
      meas(1'b0, n);
      tx_post(2'b10);
      meas(1'b0, n1);
      meas(1'b0, n2);
      check("R7 clamp sooner", n2, 7);
      tx_a_adj = 3'(-4);
      meas(1'b0, n);
      tx_post(2'b01);
      meas(1'b0, n1);
      meas(1'b0, n2);
      check("R7 clamp later", n2, 7);
      meas(1'b0, n3);
      check("R7 plain after clamp", n3, 8);

      // R9: synchronous mode
      tx_a_base = 4'd3;
      tx_b_base = 3'd2;
      tx_a_adj = '0;
      rx_a_base = 4'd7;
      rx_b_base = 3'd5;
      sync_mode = 1'b1;
      meas(1'b1, n);
      meas(1'b1, n);
      check("R9 rx period follows tx", n, 12);
      rx_a_adj = 3'(3);
      rx_adj_sel = 2'b01;
      rx_adj_valid = 1'b1;
      @(negedge clk);
      rx_adj_valid = 1'b0;
      mism = 0;
      for (int i = 0; i < 60; i++) begin
         if (rx_conv !== tx_conv || rx_fclk !== tx_fclk) mism++;
         @(negedge clk);
      end
      check("R9 rx equals tx", mism, 0);
      meas(1'b1, n);
      meas(1'b1, n);
      check("R9 rx trim ignored", n, 12);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule